// File: doc/BRIEF.md
# Compare-Driven Timer Channel

This block is one up-counting timer channel. Its count clock is the system clock divided by 2, 8, 32 or 128. A mode register selects the divide ratio and two options. With auto-reset on, the count goes back to zero after it reaches compare C, which gives a periodic event. With stop-on-C on, the channel clock switches off as the count reaches compare C, which gives a single timed event. With both options off, the counter runs freely and wraps at its full width.

Three command pulses control the channel: start clock, stop clock and software trigger. The software trigger clears the count and the prescaler phase, so a start pulse together with a trigger pulse launches a fresh interval. Three event sources set sticky status flags: compare A reached, compare C reached, and wrap. Each flag drives the interrupt line when its mask bit is set. The mask is changed only by a set-bits write and a clear-bits write. Reading the status clears the sticky flags.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count is 0, the channel clock is off, all status flags and mask bits are 0, and irq is low.
- R2: The mode register (address 0) holds the divide select in bits [1:0]. The values 0, 1, 2 and 3 make the running count advance once every 2, 8, 32 and 128 system cycles.
- R3: With auto-reset (mode bit 2) set, the count returns from compare C (address 2) to 0 on the next advance. Status bit 1 is set on the advance that brings the count to compare C.
- R4: With auto-reset clear, the count wraps from all ones to 0, and that advance sets status bit 2.
- R5: With stop-on-C (mode bit 3) set, the clock-status bit (status bit 3) clears on the advance that brings the count to compare C, and the count then holds at compare C.
- R6: A software trigger sets the count and the prescaler phase to 0. Together with start clock it runs the channel, and the first advance comes one full divide period after the trigger.
- R7: Stop clock halts counting. Start and stop in the same cycle leave the clock off.
- R8: A write to address 3 sets the mask bits given in wr_data[2:0] and keeps the other bits. A write to address 4 clears the given bits, so all ones clears every bit. irq is high exactly when a set status flag has its mask bit set.
- R9: Status bits 0 to 2 are sticky and clear on a cycle with sts_rd high, except when an event arrives in that same cycle. Status bit 3 shows whether the channel clock is on.
- R10: Status bit 0 is set on the advance that brings the count to compare A (address 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 mode, 1 compare A, 2 compare C, 3 mask set, 4 mask clear |
| wr_data | input | CNT_W | Register write data |
| clk_en_cmd | input | 1 | Start-clock command pulse |
| clk_dis_cmd | input | 1 | Stop-clock command pulse |
| sw_trig | input | 1 | Software trigger pulse |
| sts_rd | input | 1 | Status read strobe; clears the sticky flags |
| sts_q | output | 4 | Status: bit0 compare A, bit1 compare C, bit2 wrap, bit3 clock on |
| irq | output | 1 | Interrupt request |
| cnt_q | output | CNT_W | Current count |
| ien_q | output | 3 | Interrupt mask, same bit positions as status bits 0 to 2 |

## Verification
The hardest condition to reach from the ports is the wrap from all ones to zero in free-running mode. No port can preload the count, so the stimulus runs the 16-bit counter at the fastest divide for the full 65536 advances and checks the wrap flag and the zero count at the exact edge. The other hard cases are events that land in the same cycle as a status read, a stop command or a trigger. A seeded random phase creates them by using small compare values and dense command pulses, and a cycle-accurate reference model built from the requirements checks every cycle.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int DIV_W = 7;
    localparam int N_SRC = 3;

    typedef enum logic [2:0] {
        ADDR_MODE = 3'd0,
        ADDR_CMPA = 3'd1,
        ADDR_CMPC = 3'd2,
        ADDR_IEN  = 3'd3,
        ADDR_IDIS = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic       stop_on_c;
        logic       auto_rst;
        logic [1:0] div_sel;
    } mode_t;

    typedef struct packed {
        logic wrap;
        logic cmp_c;
        logic cmp_a;
    } evt_t;

    function automatic logic [DIV_W-1:0] div_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    div_mask = 7'd1;
            2'd1:    div_mask = 7'd7;
            2'd2:    div_mask = 7'd31;
            default: div_mask = 7'd127;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] ph_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = div_mask(sel);
        tick = ((ph_q & lim) == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) ph_q <= '0;
        else                ph_q <= ph_q + 1'b1;
    end

    // R6: a restart never lets the very next cycle tick
    a_r6_no_tick_after_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_c,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             trig,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output evt_t             evt
);
    logic             adv;
    logic             stop_hit;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        adv       = tick && run_q && !trig;
        nxt       = (mode.auto_rst && (cnt_q == cmp_c)) ? '0 : cnt_q + 1'b1;
        evt.cmp_a = adv && (nxt == cmp_a);
        evt.cmp_c = adv && (nxt == cmp_c);
        evt.wrap  = adv && (&cnt_q);
        stop_hit  = evt.cmp_c && mode.stop_on_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            if (trig)     cnt_q <= '0;
            else if (adv) cnt_q <= nxt;

            if (dis_cmd)       run_q <= 1'b0;
            else if (en_cmd)   run_q <= 1'b1;
            else if (stop_hit) run_q <= 1'b0;
        end
    end

    a_r6_trig_zero: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cnt_q == '0));

    a_r7_dis_wins: assert property (@(posedge clk) disable iff (rst)
        dis_cmd |=> !run_q);

    a_r5_stop_at_c: assert property (@(posedge clk) disable iff (rst)
        ($fell(run_q) && !$past(dis_cmd)) |-> (cnt_q == $past(cmp_c)));

    a_r3_auto_return: assert property (@(posedge clk) disable iff (rst)
        (adv && mode.auto_rst && (cnt_q == cmp_c)) |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
    import tmr_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  logic             sts_rd,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] flags_q,
    output logic [N_SRC-1:0] mask_q,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= (sts_rd ? '0 : flags_q) | evt;
            if (ien_wr)       mask_q <= mask_q | wdata;
            else if (idis_wr) mask_q <= mask_q & ~wdata;
        end
    end

    assign irq = |(flags_q & mask_q);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !sts_rd |=> (($past(flags_q) & ~flags_q) == '0));

    a_r8_ien_keep: assert property (@(posedge clk) disable iff (rst)
        ien_wr |=> (($past(mask_q) & ~mask_q) == '0));

    a_r8_idis_clear: assert property (@(posedge clk) disable iff (rst)
        (idis_wr && !ien_wr) |=> ((mask_q & $past(wdata)) == '0));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             clk_en_cmd,
    input  logic             clk_dis_cmd,
    input  logic             sw_trig,
    input  logic             sts_rd,
    output logic [3:0]       sts_q,
    output logic             irq,
    output logic [CNT_W-1:0] cnt_q,
    output logic [2:0]       ien_q
);
    mode_t            mode_q;
    logic [CNT_W-1:0] cmpa_q;
    logic [CNT_W-1:0] cmpc_q;
    logic             tick;
    logic             run;
    evt_t             evt;
    logic [N_SRC-1:0] flags;
    logic             ien_wr;
    logic             idis_wr;

    generate
        if (CNT_W != 16 && CNT_W != 32) begin : g_bad_width
            initial $error("tmr_chan: CNT_W must be 16 or 32");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cmpa_q <= '0;
            cmpc_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_MODE: mode_q <= mode_t'(wr_data[3:0]);
                ADDR_CMPA: cmpa_q <= wr_data;
                ADDR_CMPC: cmpc_q <= wr_data;
                default:   ;
            endcase
        end
    end

    assign ien_wr  = wr_en && (wr_addr == ADDR_IEN);
    assign idis_wr = wr_en && (wr_addr == ADDR_IDIS);

    tmr_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (sw_trig),
        .sel     (mode_q.div_sel),
        .tick    (tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (mode_q),
        .cmp_a   (cmpa_q),
        .cmp_c   (cmpc_q),
        .en_cmd  (clk_en_cmd),
        .dis_cmd (clk_dis_cmd),
        .trig    (sw_trig),
        .cnt_q   (cnt_q),
        .run_q   (run),
        .evt     (evt)
    );

    tmr_irq_ctl u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .sts_rd  (sts_rd),
        .ien_wr  (ien_wr),
        .idis_wr (idis_wr),
        .wdata   (wr_data[N_SRC-1:0]),
        .flags_q (flags),
        .mask_q  (ien_q),
        .irq     (irq)
    );

    assign sts_q = {run, flags};

    // R1: outputs quiet in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (cnt_q == '0 && sts_q == 4'd0 && !irq));

endmodule

// File: tb/tmr_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_chan_tb_top;
    localparam int CNT_W = 16;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             clk_en_cmd = 1'b0;
    logic             clk_dis_cmd = 1'b0;
    logic             sw_trig = 1'b0;
    logic             sts_rd = 1'b0;
    logic [3:0]       sts_q;
    logic             irq;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       ien_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_chan #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clk_en_cmd(clk_en_cmd), .clk_dis_cmd(clk_dis_cmd), .sw_trig(sw_trig),
        .sts_rd(sts_rd), .sts_q(sts_q), .irq(irq), .cnt_q(cnt_q), .ien_q(ien_q)
    );

    // reference model built from the requirements
    logic [6:0]       m_div;
    logic [CNT_W-1:0] m_cnt, m_a, m_c;
    logic             m_on;
    logic [2:0]       m_flags, m_mask;
    logic [3:0]       m_mode;

    function automatic logic [6:0] ratio_mask(input logic [1:0] sel);
        return 7'((2 << (2 * sel)) - 1);
    endfunction

    always @(posedge clk) begin
        logic [6:0] mk;
        logic tk, adv, stop;
        logic [CNT_W-1:0] nx;
        logic [2:0] ev;
        if (rst) begin
            m_div = '0; m_cnt = '0; m_a = '0; m_c = '0; m_on = 0;
            m_flags = '0; m_mask = '0; m_mode = '0;
        end else begin
            mk   = ratio_mask(m_mode[1:0]);
            tk   = ((m_div & mk) == mk);
            adv  = tk && m_on && !sw_trig;
            nx   = (m_mode[2] && m_cnt == m_c) ? '0 : m_cnt + 1'b1;
            ev   = {adv && (m_cnt == MAXV), adv && (nx == m_c), adv && (nx == m_a)};
            stop = ev[1] && m_mode[3];
            m_flags = (sts_rd ? 3'd0 : m_flags) | ev;
            m_on  = clk_dis_cmd ? 1'b0 : clk_en_cmd ? 1'b1 : stop ? 1'b0 : m_on;
            m_cnt = sw_trig ? '0 : adv ? nx : m_cnt;
            m_div = sw_trig ? '0 : m_div + 1'b1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_mode = wr_data[3:0];
                    3'd1: m_a = wr_data;
                    3'd2: m_c = wr_data;
                    3'd3: m_mask = m_mask | wr_data[2:0];
                    3'd4: m_mask = m_mask & ~wr_data[2:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (!rst) begin
            chk("R2 count vs model", 32'(cnt_q), 32'(m_cnt));
            chk("R9 status vs model", 32'(sts_q), 32'({m_on, m_flags}));
            chk("R8 irq vs model", 32'(irq), 32'(|(m_flags & m_mask)));
            chk("R8 mask vs model", 32'(ien_q), 32'(m_mask));
        end
        wr_en = 0; clk_en_cmd = 0; clk_dis_cmd = 0; sw_trig = 0; sts_rd = 0;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [CNT_W-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic cmd(input bit en, input bit dis, input bit trg);
        clk_en_cmd = en; clk_dis_cmd = dis; sw_trig = trg;
        step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        logic [CNT_W-1:0] held;
        void'($urandom(32'h1d5e_7a11));
        run(3);
        rst = 0;
        #1;
        chk("R1 reset count", 32'(cnt_q), 0);
        chk("R1 reset status", 32'(sts_q), 0);
        chk("R1 reset irq", 32'(irq), 0);
        chk("R1 reset mask", 32'(ien_q), 0);

        // R2 / R6: divide by 8, first advance one period after trigger
        wreg(3'd0, 16'h1);
        cmd(1, 0, 1);
        run(7);
        chk("R6 no advance before period", 32'(cnt_q), 0);
        step();
        chk("R6 first advance", 32'(cnt_q), 1);
        run(32);
        chk("R2 divide by 8", 32'(cnt_q), 5);
        chk("R6 clock on", 32'(sts_q[3]), 1);

        // R3 / R10: auto-reset with C=3, A=1
        wreg(3'd3, 16'h7);
        wreg(3'd2, 16'd3);
        wreg(3'd1, 16'd1);
        wreg(3'd0, 16'h4);
        sts_rd = 1; step();
        cmd(1, 0, 1);
        run(6);
        chk("R3 reaches C", 32'(cnt_q), 3);
        chk("R3 C flag", 32'(sts_q[1]), 1);
        run(2);
        chk("R3 returns to zero", 32'(cnt_q), 0);
        chk("R10 A flag", 32'(sts_q[0]), 1);
        chk("R8 irq on unmasked flag", 32'(irq), 1);

        // R9: read clears after stopping
        cmd(0, 1, 0);
        chk("R7 stop clears clock bit", 32'(sts_q[3]), 0);
        sts_rd = 1; step();
        chk("R9 read clears flags", 32'(sts_q[2:0]), 0);
        chk("R9 irq gone", 32'(irq), 0);

        // R7: start and stop together
        cmd(1, 1, 0);
        chk("R7 en+dis stays off", 32'(sts_q[3]), 0);
        held = cnt_q;
        run(20);
        chk("R7 count frozen", 32'(cnt_q), 32'(held));

        // R5: one-shot at C=4
        wreg(3'd2, 16'd4);
        wreg(3'd0, 16'hC);
        cmd(1, 0, 1);
        run(8);
        chk("R5 count at C", 32'(cnt_q), 4);
        chk("R5 clock stopped", 32'(sts_q[3]), 0);
        run(20);
        chk("R5 count holds", 32'(cnt_q), 4);
        chk("R9 sticky C flag", 32'(sts_q[1]), 1);

        // R8: mask set and clear
        wreg(3'd4, 16'hFFFF);
        chk("R8 clear all", 32'(ien_q), 0);
        chk("R8 irq masked", 32'(irq), 0);
        wreg(3'd3, 16'h2);
        wreg(3'd3, 16'h1);
        chk("R8 set keeps others", 32'(ien_q), 3);
        chk("R8 irq unmasked", 32'(irq), 1);
        wreg(3'd4, 16'h1);
        chk("R8 clear one bit", 32'(ien_q), 2);

        // R4: free-running full wrap at divide by 2
        wreg(3'd0, 16'h0);
        wreg(3'd1, 16'h8000);
        sts_rd = 1; step();
        cmd(1, 0, 1);
        run(2 * 65536 - 1);
        chk("R4 before wrap", 32'(cnt_q), 32'(MAXV));
        chk("R4 no wrap flag yet", 32'(sts_q[2]), 0);
        step();
        chk("R4 wrapped to zero", 32'(cnt_q), 0);
        chk("R4 wrap flag", 32'(sts_q[2]), 1);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 8) begin
                wr_en = 1; wr_addr = 3'($urandom_range(0, 4));
                wr_data = (wr_addr == 3'd0) ? CNT_W'($urandom_range(0, 15) & 4'hD)
                                            : CNT_W'($urandom_range(0, 12));
            end
            clk_en_cmd  = ($urandom_range(0, 49) == 0);
            clk_dis_cmd = ($urandom_range(0, 99) == 0);
            sw_trig     = ($urandom_range(0, 79) == 0);
            sts_rd      = ($urandom_range(0, 9) == 0);
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule